// File: doc/BRIEF.md
# Dual-Unit Issue Interlock

This block governs how instructions move through two parallel execution pipes, an arithmetic pipe and a memory pipe, each two stages deep. It also sequences a floating-point pipe that has no way to delay its completion. The block owns the occupancy bits of all four stages. Each cycle it takes one incoming instruction, tagged with its target pipe, and a per-pipe flag saying that the second-stage occupant cannot retire this cycle. From these it decides which first-stage occupants move forward, which stay put, and whether the new instruction is taken.

A second-stage instruction that cannot retire blocks the first-stage occupant of both pipes. Because the block is its own pipe's gate and the gate of the other pipe, one pipe can never move into a slot that is still busy in either pipe. A pipe whose first stage is empty still accepts work while the other pipe is blocked, so arithmetic work can overlap a pending memory access. A floating-point instruction starts only when all four stages are empty. After it starts, nothing is taken until a fixed number of cycles has passed.

Top module: `issue_interlock`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, clears all four stage occupancy bits and the floating-point busy state. After it, `accept`, `advance`, `hold` and `fpu_done` are all zero.
- R2: Bit 0 of every per-pipe vector is the arithmetic pipe and bit 1 is the memory pipe. A pipe's stall is its stage-2 valid bit ANDed with its `s2_blocked` bit. `advance[u]` is high exactly when stage 1 of pipe u is valid and neither pipe is stalled.
- R3: A stall in a pipe's own stage 2 keeps that pipe's stage-1 instruction in place, with `hold[u]` high.
- R4: A stall in the other pipe's stage 2 also keeps a valid stage-1 instruction in place, with `hold[u]` high and `advance[u]` low.
- R5: A stalled stage-2 instruction stays valid into the next cycle and is never overwritten by an advancing stage-1 instruction.
- R6: A valid stage-2 instruction whose `s2_blocked` bit is low retires. Its valid bit is clear after the edge unless a stage-1 instruction advances into it in the same cycle.
- R7: An instruction for pipe u is accepted only when stage 1 of u is empty or its occupant advances in the same cycle. This holds even while the other pipe's stage 2 is stalled.
- R8: The unit code on `in_unit` is 0 for arithmetic, 1 for memory, 2 for floating point and 3 for none. Code 3 and a low `in_valid` are never accepted, and at most one `accept` bit is high.
- R9: A floating-point instruction, reported on `accept[2]`, is accepted only when all four stage valid bits are clear and the floating-point pipe is idle.
- R10: After a floating-point accept, `fpu_busy` is high for exactly FPU_LAT cycles. `fpu_done` is high in the last of them. While `fpu_busy` is high, no instruction of any kind is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_unit | input | 2 | Target pipe code of the offered instruction |
| s2_blocked | input | 2 | Per pipe: stage-2 occupant cannot retire this cycle |
| accept | output | 3 | Offered instruction taken; bit 2 is the floating-point pipe |
| advance | output | 2 | Per pipe: stage-1 occupant moves to stage 2 this cycle |
| hold | output | 2 | Per pipe: stage-1 occupant stays in place this cycle |
| s1_valid | output | 2 | Per pipe stage-1 occupancy |
| s2_valid | output | 2 | Per pipe stage-2 occupancy |
| fpu_busy | output | 1 | Floating-point instruction in flight |
| fpu_done | output | 1 | Last cycle of the floating-point latency |

## Verification
The assertions assume that `s2_blocked` only matters when the matching stage 2 is occupied. They also assume that the environment offers at most one instruction per cycle, identified solely by `in_unit`. The stimulus raises `s2_blocked` both on occupied and on empty stages. It offers every unit code, including the unused one and offers with `in_valid` low. It never changes inputs near a clock edge, so every offer is a clean single-cycle request. Sequences are built so that blocking from each pipe is seen both by its own stage 1 and by the other pipe's stage 1.

// File: rtl/issue_interlock_pkg.sv
package issue_interlock_pkg;
   typedef enum logic [1:0] {
      PIPE_ARITH = 2'd0,
      PIPE_MEM   = 2'd1,
      PIPE_FLOAT = 2'd2,
      PIPE_NONE  = 2'd3
   } pipe_code_e;

   localparam int unsigned STAGED_PIPES = 2;
endpackage

// File: rtl/pipe_occupancy.sv
// Occupancy bits of one two-stage pipe.
module pipe_occupancy (
   input  logic clk,
   input  logic rst,
   input  logic take,        // new instruction enters stage 1
   input  logic move,        // stage 1 moves to stage 2
   input  logic s2_blocked,  // stage-2 occupant cannot retire
   output logic s1_valid,
   output logic s2_valid,
   output logic stall
);
   logic s1_q, s2_q;

   assign s1_valid = s1_q;
   assign s2_valid = s2_q;
   assign stall    = s2_q & s2_blocked;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_q <= 1'b0;
         s2_q <= 1'b0;
      end else begin
         s1_q <= take | (s1_q & ~move);
         s2_q <= move | (s2_q & s2_blocked);
      end
   end

   // A stalled stage-2 slot must never receive a new occupant.
   assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (rst)
      (s2_q && s2_blocked) |-> !move);
   assert_stall_kept_R5: assert property (@(posedge clk) disable iff (rst)
      (s2_q && s2_blocked) |=> s2_q);
   assert_retire_R6: assert property (@(posedge clk) disable iff (rst)
      (s2_q && !s2_blocked && !move) |=> !s2_q);
   assert_take_room_R7: assert property (@(posedge clk) disable iff (rst)
      take |-> (!s1_q || move));
   assert_move_needs_s1_R2: assert property (@(posedge clk) disable iff (rst)
      move |-> s1_q);
endmodule

// File: rtl/float_latency.sv
// Tracks the single in-flight floating-point instruction.
module float_latency #(
   parameter int unsigned LAT = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int unsigned CNT_W = $clog2(LAT + 1);

   logic [CNT_W-1:0] left_q;

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("float_latency: LAT must be at least 1");
      end
   endgenerate

   assign busy = (left_q != '0);
   assign done = (left_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst)
         left_q <= '0;
      else if (start)
         left_q <= CNT_W'(LAT);
      else if (busy)
         left_q <= left_q - CNT_W'(1);
   end

   assert_start_idle_R10: assert property (@(posedge clk) disable iff (rst)
      start |-> !busy);
   assert_done_ends_R10: assert property (@(posedge clk) disable iff (rst)
      done |=> !busy);
   assert_start_busy_R10: assert property (@(posedge clk) disable iff (rst)
      start |=> busy);
endmodule

// File: rtl/issue_interlock.sv
module issue_interlock #(
   parameter int unsigned FPU_LAT = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       in_valid,
   input  logic [1:0] in_unit,
   input  logic [1:0] s2_blocked,
   output logic [2:0] accept,
   output logic [1:0] advance,
   output logic [1:0] hold,
   output logic [1:0] s1_valid,
   output logic [1:0] s2_valid,
   output logic       fpu_busy,
   output logic       fpu_done
);
   import issue_interlock_pkg::*;

   localparam int unsigned NP = STAGED_PIPES;

   generate
      if (NP != 2) begin : g_bad_np
         $error("issue_interlock: exactly two staged pipes are supported");
      end
   endgenerate

   pipe_code_e    code;
   logic [NP-1:0] stall;
   logic [NP-1:0] s1_free;
   logic          any_stall;
   logic          all_empty;

   assign code      = pipe_code_e'(in_unit);
   assign any_stall = |stall;
   assign all_empty = ~(|s1_valid) & ~(|s2_valid);

   generate
      for (genvar u = 0; u < NP; u++) begin : g_pipe
         // Cross-coupled gate: either pipe's stage-2 stall freezes stage 1.
         assign advance[u] = s1_valid[u] & ~any_stall;
         assign hold[u]    = s1_valid[u] & ~advance[u];
         assign s1_free[u] = ~s1_valid[u] | advance[u];
         assign accept[u]  = in_valid & (code == pipe_code_e'(u)) &
                             s1_free[u] & ~fpu_busy;

         pipe_occupancy u_occ (
            .clk        (clk),
            .rst        (rst),
            .take       (accept[u]),
            .move       (advance[u]),
            .s2_blocked (s2_blocked[u]),
            .s1_valid   (s1_valid[u]),
            .s2_valid   (s2_valid[u]),
            .stall      (stall[u])
         );
      end
   endgenerate

   assign accept[2] = in_valid & (code == PIPE_FLOAT) & all_empty & ~fpu_busy;

   float_latency #(.LAT(FPU_LAT)) u_float (
      .clk   (clk),
      .rst   (rst),
      .start (accept[2]),
      .busy  (fpu_busy),
      .done  (fpu_done)
   );

   assert_cross_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (s2_valid[1] && s2_blocked[1] && s1_valid[0]) |-> (hold[0] && !advance[0]));
   assert_cross_hold_mem_R4: assert property (@(posedge clk) disable iff (rst)
      (s2_valid[0] && s2_blocked[0] && s1_valid[1]) |-> (hold[1] && !advance[1]));
   assert_one_accept_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(accept));
   assert_float_excl_R10: assert property (@(posedge clk) disable iff (rst)
      fpu_busy |-> (accept == 3'b000));
   assert_float_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      accept[2] |=> (s1_valid == 2'b00));
endmodule

// File: tb/issue_interlock_test.sv
`timescale 1ns/1ps
module issue_interlock_test;
   logic       clk = 1'b0;
   logic       rst;
   logic       in_valid;
   logic [1:0] in_unit;
   logic [1:0] s2_blocked;
   logic [2:0] accept;
   logic [1:0] advance, hold, s1_valid, s2_valid;
   logic       fpu_busy, fpu_done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit ended  = 1'b0;

   always #2 clk = ~clk;

   issue_interlock #(.FPU_LAT(4)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
      .s2_blocked(s2_blocked), .accept(accept), .advance(advance),
      .hold(hold), .s1_valid(s1_valid), .s2_valid(s2_valid),
      .fpu_busy(fpu_busy), .fpu_done(fpu_done)
   );

   task automatic chk(input string req, input string what,
                      input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
      end
   endtask

   // {in_valid, in_unit, s2_blocked, accept, advance, s1 after, s2 after}
   localparam logic [13:0] VEC [0:21] = '{
      14'b1_00_00_001_00_01_00, // R7 arith into empty pipe
      14'b1_01_00_010_01_10_01, // R2 arith advances, mem accepted
      14'b1_00_01_001_00_11_01, // R3 R4 arith s2 stall holds both
      14'b0_00_01_000_00_11_01, // R5 stall persists
      14'b0_00_00_000_11_00_11, // R6 retire, both advance
      14'b1_00_10_001_00_01_10, // R7 arith taken while mem s2 stalled
      14'b1_01_10_010_00_11_10, // R4 arith held by mem stall
      14'b1_00_10_000_00_11_10, // R7 full stage 1 refuses
      14'b1_00_00_001_11_01_11, // R7 accept into advancing slot
      14'b1_10_00_000_01_00_01, // R9 float refused, pipes busy
      14'b1_11_00_000_00_00_00, // R8 code 3 never accepted
      14'b0_01_00_000_00_00_00, // R8 in_valid low
      14'b1_10_00_100_00_00_00, // R9 float into idle pipes
      14'b1_00_00_000_00_00_00, // R10 busy 1
      14'b1_00_00_000_00_00_00, // R10 busy 2
      14'b1_00_00_000_00_00_00, // R10 busy 3
      14'b1_00_00_000_00_00_00, // R10 busy 4
      14'b1_00_00_001_00_01_00, // R10 released
      14'b1_10_00_000_01_00_01, // R9 stage 1 occupied
      14'b1_10_01_000_00_00_01, // R9 stalled stage 2 occupied
      14'b1_10_00_000_00_00_00, // R9 stage 2 retiring still occupied
      14'b1_10_00_100_00_00_00  // R9 float accepted
   };

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !ended) begin
         ended = 1'b1;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [1:0] pre_s1;
      rst = 1'b1; in_valid = 1'b0; in_unit = 2'd0; s2_blocked = 2'b00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1", "s1_valid", 8'(s1_valid), 8'd0);
      chk("R1", "s2_valid", 8'(s2_valid), 8'd0);
      chk("R1", "fpu_busy", 8'(fpu_busy), 8'd0);
      chk("R1", "advance/hold", 8'({advance, hold}), 8'd0);
      pre_s1 = 2'b00;

      for (int i = 0; i < 22; i++) begin
         @(negedge clk);
         in_valid   = VEC[i][13];
         in_unit    = VEC[i][12:11];
         s2_blocked = VEC[i][10:9];
         #1;
         chk("R7/R8/R9", $sformatf("accept step %0d", i), 8'(accept), 8'(VEC[i][8:6]));
         chk("R2/R4", $sformatf("advance step %0d", i), 8'(advance), 8'(VEC[i][5:4]));
         chk("R3", $sformatf("hold step %0d", i), 8'(hold), 8'(pre_s1 & ~VEC[i][5:4]));
         @(posedge clk);
         #1;
         chk("R5/R6", $sformatf("s1 after step %0d", i), 8'(s1_valid), 8'(VEC[i][3:2]));
         chk("R5/R6", $sformatf("s2 after step %0d", i), 8'(s2_valid), 8'(VEC[i][1:0]));
         pre_s1 = VEC[i][3:2];
      end

      // R10: float accepted in last step; busy four cycles, done on the fourth.
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 1; k <= 4; k++) begin
         #1;
         chk("R10", $sformatf("busy cycle %0d", k), 8'(fpu_busy), 8'd1);
         chk("R10", $sformatf("done cycle %0d", k), 8'(fpu_done), 8'(k == 4));
         @(negedge clk);
      end
      #1;
      chk("R10", "busy released", 8'(fpu_busy), 8'd0);
      chk("R10", "done released", 8'(fpu_done), 8'd0);

      // R1: reset in the middle of traffic.
      @(negedge clk);
      in_valid = 1'b1; in_unit = 2'd0;
      @(negedge clk);
      in_unit = 2'd1; s2_blocked = 2'b11;
      @(negedge clk);
      in_valid = 1'b1; in_unit = 2'd2; rst = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b0;
      #1;
      chk("R1", "s1 after mid reset", 8'(s1_valid), 8'd0);
      chk("R1", "s2 after mid reset", 8'(s2_valid), 8'd0);
      chk("R1", "busy after mid reset", 8'(fpu_busy), 8'd0);
      chk("R1", "accept after mid reset", 8'(accept), 8'd0);
      s2_blocked = 2'b00;

      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule